// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM

This block is a clocked memory of 4096 sixteen-bit words with two independent ports, named left and right. Each port has its own address, write data, read data and active-low controls: a select, a write strobe, an output enable, a shared-flag select and two byte selects. Either port may read or write any word in any cycle, and both ports may use the same word at the same time.

The controls on each port are decoded into one mode per cycle. In a write, only the byte lanes whose select is low are stored. In a read, only the selected lanes drive data. A low shared-flag select moves the cycle away from the array, so the port neither stores nor drives. Tri-state outputs are not used. Instead, each port returns a 16-bit word together with a 2-bit drive mask, one bit for each lane. Bit 1 is the upper lane (bits 15:8) and bit 0 is the lower lane (bits 7:0). A lane that is not driven reads as zero.

Writes take effect at the clock edge that samples the request. Read data and the drive mask appear one cycle after the request.

Top module: `dpr_byte_ram`

## Requirements
- R1: A word written at any address, from 0 to 4095, is returned by a later read of that address. Read data and the drive mask are valid in the cycle after the read request.
- R2: While a port's select is high, that port writes nothing, and in the next cycle its drive mask is 2'b00.
- R3: While select is low and the shared-flag select is low, the array is not accessed. Nothing is written, and in the next cycle the drive mask is 2'b00.
- R4: A write (select low, flag select high, write strobe low) stores bits 15:8 when the upper select is low and bits 7:0 when the lower select is low. A lane that is not selected keeps its old contents. A write cycle drives no lanes.
- R5: A read (select low, flag select high, write strobe high, output enable low) returns a drive mask of {~upper_sel_n, ~lower_sel_n}. Any lane that is not driven reads as 8'h00.
- R6: When output enable is high and no write takes place, the drive mask is 2'b00.
- R7: When both byte selects are high, nothing is written and nothing is driven.
- R8: The two ports work independently, and both may read the same address in the same cycle and get the same word.
- R9: When both ports write the same lane of the same address in one cycle, the left port's byte is kept. Writes from the two ports to different lanes of one word both land.
- R10: A read that collides with a write to the same address in the same cycle returns the data held before that write.
- R11: After reset, both ports show drive mask 2'b00 and read data 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_sel_n | input | 1 | Left port select, active low |
| lt_wr_n | input | 1 | Left write strobe: low writes, high reads |
| lt_oen_n | input | 1 | Left output enable, active low |
| lt_flag_n | input | 1 | Left shared-flag select; must be high for array access |
| lt_hi_n | input | 1 | Left upper byte select, active low |
| lt_lo_n | input | 1 | Left lower byte select, active low |
| lt_addr | input | 12 | Left word address |
| lt_wdata | input | 16 | Left write data |
| lt_rdata | output | 16 | Left read data; lanes that are not driven are zero |
| lt_drive | output | 2 | Left lane drive mask {upper, lower} |
| rt_sel_n | input | 1 | Right port select, active low |
| rt_wr_n | input | 1 | Right write strobe: low writes, high reads |
| rt_oen_n | input | 1 | Right output enable, active low |
| rt_flag_n | input | 1 | Right shared-flag select; must be high for array access |
| rt_hi_n | input | 1 | Right upper byte select, active low |
| rt_lo_n | input | 1 | Right lower byte select, active low |
| rt_addr | input | 12 | Right word address |
| rt_wdata | input | 16 | Right write data |
| rt_rdata | output | 16 | Right read data; lanes that are not driven are zero |
| rt_drive | output | 2 | Right lane drive mask {upper, lower} |

## Verification
The assertions check the drive mask on every cycle against the controls of the cycle before. A deselected port, a cycle with the flag select low, a write and a high output enable must each give a zero mask, and a read must give a mask that follows the byte selects. Only the bench scenarios can show what the array stores. That covers partial-lane merges, the left port winning a same-lane write clash, read-before-write on a collision, words left unchanged by ignored cycles, and the top address.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2,
    MODE_FLAG  = 2'd3
  } port_mode_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode
  import dpr_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             oen_n,
  input  logic             flag_n,
  input  logic [LANES-1:0] bsel_n,
  output port_mode_e       mode,
  output logic [LANES-1:0] wr_lanes,
  output logic [LANES-1:0] rd_lanes
);
  logic [LANES-1:0] lane_on;

  always_comb begin
    if (sel_n)        mode = MODE_IDLE;
    else if (!flag_n) mode = MODE_FLAG;
    else if (!wr_n)   mode = MODE_WRITE;
    else if (!oen_n)  mode = MODE_READ;
    else              mode = MODE_IDLE;
  end

  always_comb begin
    lane_on  = ~bsel_n;
    wr_lanes = '0;
    rd_lanes = '0;
    if (mode == MODE_WRITE) wr_lanes = lane_on;
    if (mode == MODE_READ)  rd_lanes = lane_on;
  end
endmodule

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WIDTH  = 8
) (
  input  logic              clk,
  input  logic              l_we,
  input  logic              l_re,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [WIDTH-1:0]  l_wd,
  output logic [WIDTH-1:0]  l_q,
  input  logic              r_we,
  input  logic              r_re,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [WIDTH-1:0]  r_wd,
  output logic [WIDTH-1:0]  r_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] store [DEPTH];
  logic             r_we_eff;

  // left port has priority on a same-lane, same-address clash
  always_comb r_we_eff = r_we && !(l_we && (l_addr == r_addr));

  always_ff @(posedge clk) begin
    if (r_we_eff) store[r_addr] <= r_wd;
    if (l_we)     store[l_addr] <= l_wd;
  end

  // reads sample the array before this edge's writes land
  always_ff @(posedge clk) begin
    if (l_re) l_q <= store[l_addr];
    if (r_re) r_q <= store[r_addr];
  end
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out
  import dpr_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        rd_lanes,
  input  logic [LANES*LANE_W-1:0] lane_q,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        drive
);
  logic [LANES-1:0] drive_d, drive_q;

  always_comb drive_d = rd_lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= '0;
    else        drive_q <= drive_d;
  end

  assign drive = drive_q;

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign rdata[g*LANE_W +: LANE_W] = drive_q[g] ? lane_q[g*LANE_W +: LANE_W] : '0;
  end

  p_undriven_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive == '0) |-> (rdata == '0));
endmodule

// File: rtl/dpr_byte_ram.sv
module dpr_byte_ram
  import dpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lt_sel_n,
  input  logic              lt_wr_n,
  input  logic              lt_oen_n,
  input  logic              lt_flag_n,
  input  logic              lt_hi_n,
  input  logic              lt_lo_n,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic [DATA_W-1:0] lt_wdata,
  output logic [DATA_W-1:0] lt_rdata,
  output logic [1:0]        lt_drive,
  input  logic              rt_sel_n,
  input  logic              rt_wr_n,
  input  logic              rt_oen_n,
  input  logic              rt_flag_n,
  input  logic              rt_hi_n,
  input  logic              rt_lo_n,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic [DATA_W-1:0] rt_wdata,
  output logic [DATA_W-1:0] rt_rdata,
  output logic [1:0]        rt_drive
);
  localparam int unsigned LANES = DATA_W / LANE_W;

  port_mode_e       lt_mode, rt_mode;
  logic [LANES-1:0] lt_wl, lt_rl, rt_wl, rt_rl;
  logic [DATA_W-1:0] lt_q, rt_q;

  dpr_port_decode #(.LANES(LANES)) u_dec_lt (
    .sel_n(lt_sel_n), .wr_n(lt_wr_n), .oen_n(lt_oen_n), .flag_n(lt_flag_n),
    .bsel_n({lt_hi_n, lt_lo_n}), .mode(lt_mode), .wr_lanes(lt_wl), .rd_lanes(lt_rl));

  dpr_port_decode #(.LANES(LANES)) u_dec_rt (
    .sel_n(rt_sel_n), .wr_n(rt_wr_n), .oen_n(rt_oen_n), .flag_n(rt_flag_n),
    .bsel_n({rt_hi_n, rt_lo_n}), .mode(rt_mode), .wr_lanes(rt_wl), .rd_lanes(rt_rl));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dpr_lane_bank #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_bank (
      .clk(clk),
      .l_we(lt_wl[g]), .l_re(lt_rl[g]), .l_addr(lt_addr),
      .l_wd(lt_wdata[g*LANE_W +: LANE_W]), .l_q(lt_q[g*LANE_W +: LANE_W]),
      .r_we(rt_wl[g]), .r_re(rt_rl[g]), .r_addr(rt_addr),
      .r_wd(rt_wdata[g*LANE_W +: LANE_W]), .r_q(rt_q[g*LANE_W +: LANE_W]));
  end

  dpr_port_out #(.LANES(LANES)) u_out_lt (
    .clk(clk), .rst_n(rst_n), .rd_lanes(lt_rl), .lane_q(lt_q),
    .rdata(lt_rdata), .drive(lt_drive));

  dpr_port_out #(.LANES(LANES)) u_out_rt (
    .clk(clk), .rst_n(rst_n), .rd_lanes(rt_rl), .lane_q(rt_q),
    .rdata(rt_rdata), .drive(rt_drive));

  p_lt_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lt_sel_n |=> (lt_drive == 2'b00));
  p_rt_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rt_sel_n |=> (rt_drive == 2'b00));
  p_lt_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_sel_n && !lt_flag_n) |=> (lt_drive == 2'b00));
  p_lt_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_sel_n && lt_flag_n && !lt_wr_n) |=> (lt_drive == 2'b00));
  p_lt_read_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_sel_n && lt_flag_n && lt_wr_n && !lt_oen_n)
      |=> (lt_drive == ~$past({lt_hi_n, lt_lo_n})));
  p_rt_read_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_sel_n && rt_flag_n && rt_wr_n && !rt_oen_n)
      |=> (rt_drive == ~$past({rt_hi_n, rt_lo_n})));
  p_lt_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lt_oen_n |=> (lt_drive == 2'b00));
  p_rt_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rt_oen_n |=> (rt_drive == 2'b00));
  p_lt_no_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_hi_n && lt_lo_n) |=> (lt_drive == 2'b00));
endmodule

// File: tb/sim_dpr_byte_ram.sv
module sim_dpr_byte_ram;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lt_sel_n, lt_wr_n, lt_oen_n, lt_flag_n, lt_hi_n, lt_lo_n;
  logic [11:0] lt_addr;
  logic [15:0] lt_wdata, lt_rdata;
  logic [1:0]  lt_drive;
  logic        rt_sel_n, rt_wr_n, rt_oen_n, rt_flag_n, rt_hi_n, rt_lo_n;
  logic [11:0] rt_addr;
  logic [15:0] rt_wdata, rt_rdata;
  logic [1:0]  rt_drive;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpr_byte_ram u0 (
    .clk(clk), .rst_n(rst_n),
    .lt_sel_n(lt_sel_n), .lt_wr_n(lt_wr_n), .lt_oen_n(lt_oen_n), .lt_flag_n(lt_flag_n),
    .lt_hi_n(lt_hi_n), .lt_lo_n(lt_lo_n), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
    .lt_rdata(lt_rdata), .lt_drive(lt_drive),
    .rt_sel_n(rt_sel_n), .rt_wr_n(rt_wr_n), .rt_oen_n(rt_oen_n), .rt_flag_n(rt_flag_n),
    .rt_hi_n(rt_hi_n), .rt_lo_n(rt_lo_n), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
    .rt_rdata(rt_rdata), .rt_drive(rt_drive));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // controls in order: sel_n, wr_n, oen_n, flag_n, hi_n, lo_n
  task automatic set_lt(input logic [5:0] c, input logic [11:0] a, input logic [15:0] d);
    {lt_sel_n, lt_wr_n, lt_oen_n, lt_flag_n, lt_hi_n, lt_lo_n} = c;
    lt_addr = a; lt_wdata = d;
  endtask

  task automatic set_rt(input logic [5:0] c, input logic [11:0] a, input logic [15:0] d);
    {rt_sel_n, rt_wr_n, rt_oen_n, rt_flag_n, rt_hi_n, rt_lo_n} = c;
    rt_addr = a; rt_wdata = d;
  endtask

  localparam logic [5:0] IDLE = 6'b111111;
  localparam logic [5:0] WR_B = 6'b001100, WR_U = 6'b001101, WR_L = 6'b001110;
  localparam logic [5:0] RD_B = 6'b010100, RD_U = 6'b010101, RD_L = 6'b010110;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_both();
    set_lt(IDLE, '0, '0);
    set_rt(IDLE, '0, '0);
  endtask

  task automatic lt_read_chk(input string req, input logic [11:0] a,
                             input logic [15:0] exp, input logic [1:0] mask);
    set_lt(RD_B, a, '0); tick(); idle_both();
    chk(req, lt_rdata, exp); chk(req, {14'd0, lt_drive}, {14'd0, mask});
  endtask

  task automatic t_reset();
    chk("R11", lt_rdata, 16'h0000); chk("R11", {14'd0, lt_drive}, 16'h0);
    chk("R11", rt_rdata, 16'h0000); chk("R11", {14'd0, rt_drive}, 16'h0);
  endtask

  task automatic t_basic();
    set_lt(WR_B, 12'd5, 16'h1234); tick(); idle_both();
    chk("R4", {14'd0, lt_drive}, 16'h0);
    lt_read_chk("R1", 12'd5, 16'h1234, 2'b11);
    set_rt(WR_B, 12'hFFF, 16'hBEEF); tick(); idle_both();
    lt_read_chk("R1", 12'hFFF, 16'hBEEF, 2'b11);
    set_lt(RD_B, 12'd5, '0); set_rt(RD_B, 12'd5, '0); tick(); idle_both();
    chk("R8", lt_rdata, 16'h1234); chk("R8", rt_rdata, 16'h1234);
  endtask

  task automatic t_lanes();
    set_lt(WR_B, 12'd10, 16'hAAAA); tick();
    set_lt(WR_U, 12'd10, 16'h5511); tick();
    set_lt(WR_L, 12'd10, 16'h33CC); tick(); idle_both();
    lt_read_chk("R4", 12'd10, 16'h55CC, 2'b11);
    set_lt(RD_U, 12'd10, '0); tick(); idle_both();
    chk("R5", lt_rdata, 16'h5500); chk("R5", {14'd0, lt_drive}, 16'h2);
    set_rt(RD_L, 12'd10, '0); tick(); idle_both();
    chk("R5", rt_rdata, 16'h00CC); chk("R5", {14'd0, rt_drive}, 16'h1);
  endtask

  task automatic t_ignored();
    set_lt(6'b101100, 12'd10, 16'hFFFF); tick(); idle_both();
    chk("R2", {14'd0, lt_drive}, 16'h0);
    lt_read_chk("R2", 12'd10, 16'h55CC, 2'b11);
    set_lt(6'b001000, 12'd10, 16'hFFFF); tick(); idle_both();
    lt_read_chk("R3", 12'd10, 16'h55CC, 2'b11);
    set_lt(6'b010000, 12'd10, '0); tick(); idle_both();
    chk("R3", {14'd0, lt_drive}, 16'h0); chk("R3", lt_rdata, 16'h0);
    set_lt(6'b001111, 12'd10, 16'hFFFF); tick(); idle_both();
    lt_read_chk("R7", 12'd10, 16'h55CC, 2'b11);
    set_lt(6'b010111, 12'd10, '0); tick(); idle_both();
    chk("R7", {14'd0, lt_drive}, 16'h0);
    set_rt(6'b011100, 12'd10, '0); tick(); idle_both();
    chk("R6", {14'd0, rt_drive}, 16'h0); chk("R6", rt_rdata, 16'h0);
  endtask

  task automatic t_collide();
    set_lt(WR_B, 12'd20, 16'h1111); set_rt(WR_B, 12'd20, 16'h2222); tick(); idle_both();
    lt_read_chk("R9", 12'd20, 16'h1111, 2'b11);
    set_lt(WR_U, 12'd21, 16'hAB00); set_rt(WR_L, 12'd21, 16'h00CD); tick(); idle_both();
    lt_read_chk("R9", 12'd21, 16'hABCD, 2'b11);
    set_lt(WR_B, 12'd30, 16'h7777); tick();
    set_lt(WR_B, 12'd30, 16'h8888); set_rt(RD_B, 12'd30, '0); tick(); idle_both();
    chk("R10", rt_rdata, 16'h7777);
    lt_read_chk("R10", 12'd30, 16'h8888, 2'b11);
  endtask

  initial begin
    rst_n = 1'b0;
    idle_both();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_basic();
    t_lanes();
    t_ignored();
    t_collide();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule